// File: doc/BRIEF.md
# E1 Receive Error Counters with Interrupt Vectoring

This block keeps four performance-monitoring counters for an E1 receiver. Three of them are 8 bits wide and count frame-alignment errors, CRC-4 errors and E-bit errors. The fourth is 16 bits wide and counts bipolar violations. Each counter advances once for every cycle in which its one-cycle event strobe is high. A host reads the counters through a small register port. It can also preset any counter from a load word, which is applied on the rising edge of that counter's load-control bit.

Every counter can raise two requests. The step request is raised whenever the counter's least significant bit changes. The wrap request is raised when an increment carries the counter from all ones back to zero. The eight requests latch as pending. A per-source mask bit hides a request from the outputs. A global suspend bit hides all of them without touching the mask. The block drives one interrupt line and an 8-bit one-hot vector that names the highest-priority visible request. Reading the vector register clears the request it reports.

Top module: `e1pm_cnt_irq`

## Requirements
- R1: Counter 0 (frame errors), counter 1 (CRC-4 errors) and counter 2 (E-bit errors) are 8 bits wide, and counter 3 (bipolar violations) is 16 bits wide. Each counter increments by one for each cycle in which its strobe `evt_i[n]` is high. It wraps to zero and keeps counting.
- R2: The register map uses 4-bit addresses. Address 0, 1 and 2 read counters 0, 1 and 2. Address 3 reads the low byte of counter 3 and address 4 reads its high byte. Writes to addresses 0 to 4 set the matching load-word byte. Address 5 is the load-control register, bits 3:0. Address 6 is the mask register. Bit 0 of address 7 is suspend. Address 8 is the vector register. `rdata` is valid on the cycle after `rd_en`.
- R3: A counter takes its load word only on a 0-to-1 change of its load-control bit. Holding the bit high loads nothing more.
- R4: When a load and an event for the same counter fall in the same cycle, the load wins and the event is lost.
- R5: A counter's step request is set whenever its least significant bit changes, whether by increment or by load.
- R6: A counter's wrap request is set when an increment takes it from all ones to zero. A load never sets it.
- R7: Mask bit i set to 1 hides source i. The mask resets to 8'hFC, so only source 0 (frame step) and source 1 (bipolar wrap) are visible. A request latches as pending even while it is masked.
- R8: While suspend is 1, `irq_o` is 0 and `vec_o` is 0. The mask and the pending requests are kept. A read of the vector register returns 0 and clears nothing.
- R9: Sources in priority order, highest first, with their vector codes: 0 frame step 8'h10, 1 bipolar wrap 8'h20, 2 CRC step 8'h01, 3 E-bit step 8'h02, 4 bipolar step 8'h04, 5 frame wrap 8'h08, 6 CRC wrap 8'h40, 7 E-bit wrap 8'h80. `vec_o` shows the code of the highest visible pending source, or 0 when there is none. `irq_o` is high exactly when `vec_o` is nonzero.
- R10: Reading the vector register returns `vec_o` and clears the reported source. If the same source is set again in that cycle, it stays pending.
- R11: After reset, all counters, load words and load-control bits are 0, nothing is pending, suspend is 0, and `irq_o` and `vec_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 4 | One-cycle event strobes, one per counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 8 | One-hot vector code of the reported source |

## Verification
Assertions check on every cycle that the frame counter steps by exactly one per strobe, holds when idle, and takes its load word over a concurrent event. They also check that suspend silences both outputs, and that the vector stays one-hot and agrees with the interrupt line. The bench scenarios cover the rest. They show the full 8-bit wrap after 256 events, the 16-bit carry and wrap, and the edge-only behaviour of the load bits. They also show that requests latch while masked, how simultaneous requests are ordered, and that the read clears only the reported request.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;
  localparam int N_CNT = 4;
  localparam int N_SRC = 8;
  localparam int VEC_W = 8;

  function automatic logic [VEC_W-1:0] src_code(input int idx);
    case (idx)
      0: src_code = 8'h10;
      1: src_code = 8'h20;
      2: src_code = 8'h01;
      3: src_code = 8'h02;
      4: src_code = 8'h04;
      5: src_code = 8'h08;
      6: src_code = 8'h40;
      default: src_code = 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/e1pm_err_cnt.sv
module e1pm_err_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tog_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (ld_i)       cnt_n = ld_val_i;
    else if (evt_i) cnt_n = cnt_q + 1'b1;
  end

  assign tog_o  = cnt_n[0] ^ cnt_q[0];
  assign wrap_o = evt_i & ~ld_i & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/e1pm_irq_ctrl.sv
module e1pm_irq_ctrl
  import e1pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             susp_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] pend_q, vis, sel_n, sel_q;
  logic [VEC_W-1:0] vec_n;

  assign vis   = pend_q & ~mask_i & {N_SRC{~susp_i}};
  assign sel_n = vis & (~vis + 1'b1);

  always_comb begin
    vec_n = '0;
    for (int i = 0; i < N_SRC; i++)
      if (sel_n[i]) vec_n = vec_n | src_code(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      sel_q  <= '0;
      vec_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(clr_i ? sel_q : '0)) | set_i;
      sel_q  <= sel_n;
      vec_o  <= vec_n;
      irq_o  <= |vis;
    end
  end
endmodule

// File: rtl/e1pm_cnt_irq.sv
module e1pm_cnt_irq
  import e1pm_pkg::*;
#(
  parameter int                DW       = 8,
  parameter int                AW       = 4,
  parameter logic [N_SRC-1:0]  MASK_RST = 8'hFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CNT-1:0] evt_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int BPV_W = 2 * DW;
  localparam logic [AW-1:0] A_BPVL = AW'(3);
  localparam logic [AW-1:0] A_BPVH = AW'(4);
  localparam logic [AW-1:0] A_LDC  = AW'(5);
  localparam logic [AW-1:0] A_MASK = AW'(6);
  localparam logic [AW-1:0] A_CTRL = AW'(7);
  localparam logic [AW-1:0] A_VEC  = AW'(8);

  logic [N_CNT-1:0] ldctl_q, ldctl_d, ld_pulse, tog, wrap;
  logic [N_SRC-1:0] mask_q, set;
  logic             susp_q, vec_clr;
  logic [DW-1:0]    cnt_lo [N_CNT];
  logic [DW-1:0]    bpv_hi, fe_cnt, fe_ldw;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldctl_q <= '0;
      ldctl_d <= '0;
      mask_q  <= MASK_RST;
      susp_q  <= 1'b0;
    end else begin
      ldctl_d <= ldctl_q;
      if (wr_en) begin
        case (addr)
          A_LDC:   ldctl_q <= wdata[N_CNT-1:0];
          A_MASK:  mask_q  <= wdata[N_SRC-1:0];
          A_CTRL:  susp_q  <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign ld_pulse = ldctl_q & ~ldctl_d;

  for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
    localparam int W = (c == N_CNT - 1) ? BPV_W : DW;
    logic [W-1:0] lw, q;

    if (c < N_CNT - 1) begin : g_narrow
      always_ff @(posedge clk) begin
        if (rst)                             lw <= '0;
        else if (wr_en && addr == AW'(c))    lw <= wdata;
      end
    end else begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) lw <= '0;
        else if (wr_en && addr == A_BPVL) lw[DW-1:0]    <= wdata;
        else if (wr_en && addr == A_BPVH) lw[BPV_W-1:DW] <= wdata;
      end
      assign bpv_hi = q[BPV_W-1:DW];
    end

    if (c == 0) begin : g_fe
      assign fe_ldw = lw;
    end

    e1pm_err_cnt #(.W(W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt_i[c]),
      .ld_i     (ld_pulse[c]),
      .ld_val_i (lw),
      .cnt_o    (q),
      .tog_o    (tog[c]),
      .wrap_o   (wrap[c])
    );
    assign cnt_lo[c] = q[DW-1:0];
  end

  assign fe_cnt = cnt_lo[0];

  // Source order sets priority: index 0 highest.
  assign set = {wrap[2], wrap[1], wrap[0], tog[3], tog[2], tog[1], wrap[3], tog[0]};
  assign vec_clr = rd_en && (addr == A_VEC);

  e1pm_irq_ctrl u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set),
    .mask_i (mask_q),
    .susp_i (susp_q),
    .clr_i  (vec_clr),
    .irq_o  (irq_o),
    .vec_o  (vec_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        AW'(0):  rdata <= cnt_lo[0];
        AW'(1):  rdata <= cnt_lo[1];
        AW'(2):  rdata <= cnt_lo[2];
        A_BPVL:  rdata <= cnt_lo[3];
        A_BPVH:  rdata <= bpv_hi;
        A_LDC:   rdata <= DW'(ldctl_q);
        A_MASK:  rdata <= DW'(mask_q);
        A_CTRL:  rdata <= DW'(susp_q);
        A_VEC:   rdata <= DW'(vec_o);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/e1pm_cnt_irq_chk.sv
module e1pm_cnt_irq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    evt_i,
  input logic [3:0]    ld_pulse,
  input logic [DW-1:0] fe_cnt,
  input logic [DW-1:0] fe_ldw,
  input logic          susp_q,
  input logic          irq_o,
  input logic [7:0]    vec_o
);
  AST_FE_STEP: assert property (@(posedge clk) disable iff (rst)
    (evt_i[0] && !ld_pulse[0]) |=> fe_cnt == DW'($past(fe_cnt) + 1'b1)); // R1
  AST_FE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!evt_i[0] && !ld_pulse[0]) |=> $stable(fe_cnt)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_pulse[0] |=> fe_cnt == $past(fe_ldw)); // R4
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(susp_q) |-> (!irq_o && vec_o == 8'h00)); // R8
  AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_o)); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == (vec_o != 8'h00)); // R9
endmodule

bind e1pm_cnt_irq e1pm_cnt_irq_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt_i    (evt_i),
  .ld_pulse (ld_pulse),
  .fe_cnt   (fe_cnt),
  .fe_ldw   (fe_ldw),
  .susp_q   (susp_q),
  .irq_o    (irq_o),
  .vec_o    (vec_o)
);

// File: tb/e1pm_cnt_irq_tb.sv
module e1pm_cnt_irq_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic [3:0] evt = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, vec_o;
  logic       irq_o;
  int         total = 0, fails = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  e1pm_cnt_irq u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = 0;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state, R2 register map
    check("R11 irq", {15'd0, irq_o}, 16'd0);
    check("R11 vec", {8'd0, vec_o}, 16'd0);
    for (int a = 0; a < 5; a++) rdchk("R11 counter", 4'(a), 8'h00);
    rdchk("R2 mask reset", 4'd6, 8'hFC);
    rdchk("R11 suspend", 4'd7, 8'h00);
    rdchk("R11 ldctl", 4'd5, 8'h00);

    // R1 R5 frame counter sweep past wrap
    for (int k = 0; k < 260; k++) begin
      pulse(4'b0001);
      rdchk("R1 frame count", 4'd0, 8'((k + 1) % 256));
      rdchk("R5 frame step vector", 4'd8, 8'h10);
    end
    // R7 wrap latched while masked
    wr(4'd6, 8'hDC);
    @(negedge clk);
    check("R7 irq after unmask", {15'd0, irq_o}, 16'd1);
    rdchk("R6 frame wrap vector", 4'd8, 8'h08);
    rdchk("R10 cleared", 4'd8, 8'h00);
    @(negedge clk);
    check("R10 irq low", {15'd0, irq_o}, 16'd0);

    // R3 R1 bipolar counter
    wr(4'd3, 8'hFE); wr(4'd4, 8'hFF); wr(4'd5, 8'h08);
    rdchk("R3 bpv lo", 4'd3, 8'hFE);
    rdchk("R3 bpv hi", 4'd4, 8'hFF);
    pulse(4'b1000); pulse(4'b1000);
    rdchk("R6 bpv wrap vector", 4'd8, 8'h20);
    rdchk("R1 bpv lo wrapped", 4'd3, 8'h00);
    rdchk("R1 bpv hi wrapped", 4'd4, 8'h00);
    wr(4'd5, 8'h08);
    rdchk("R3 held bit no reload", 4'd3, 8'h00);
    wr(4'd5, 8'h00); wr(4'd5, 8'h08);
    rdchk("R3 reload lo", 4'd3, 8'hFE);
    rdchk("R3 reload hi", 4'd4, 8'hFF);

    // R4 load beats same-cycle event
    wr(4'd1, 8'h55); wr(4'd5, 8'h00);
    @(negedge clk); wr_en = 1; addr = 4'd5; wdata = 8'h02;
    @(negedge clk); wr_en = 0; evt = 4'b0010;
    @(negedge clk); evt = 0;
    rdchk("R4 load wins", 4'd1, 8'h55);

    // R5 step from load
    wr(4'd6, 8'hD8);
    rdchk("R5 crc step from load", 4'd8, 8'h01);
    rdchk("R10 cleared crc", 4'd8, 8'h00);

    // R9 priority
    pulse(4'b0011);
    rdchk("R9 first frame step", 4'd8, 8'h10);
    rdchk("R9 then crc step", 4'd8, 8'h01);
    rdchk("R9 none left", 4'd8, 8'h00);
    rdchk("R1 frame count", 4'd0, 8'h05);
    rdchk("R1 crc count", 4'd1, 8'h56);

    // R8 suspend
    wr(4'd7, 8'h01);
    pulse(4'b0001);
    @(negedge clk);
    check("R8 irq suspended", {15'd0, irq_o}, 16'd0);
    check("R8 vec suspended", {8'd0, vec_o}, 16'd0);
    rdchk("R8 vector read suspended", 4'd8, 8'h00);
    rdchk("R8 mask unchanged", 4'd6, 8'hD8);
    wr(4'd7, 8'h00);
    @(negedge clk);
    check("R8 pending kept vec", {8'd0, vec_o}, 16'h0010);
    check("R8 pending kept irq", {15'd0, irq_o}, 16'd1);
    rdchk("R10 clear after resume", 4'd8, 8'h10);

    // R6 E-bit wrap
    wr(4'd2, 8'hFF); wr(4'd5, 8'h04);
    rdchk("R3 ebit loaded", 4'd2, 8'hFF);
    pulse(4'b0100);
    wr(4'd6, 8'h58);
    rdchk("R6 ebit wrap vector", 4'd8, 8'h80);
    rdchk("R1 ebit wrapped", 4'd2, 8'h00);

    finish_run();
  end
endmodule